// File: doc/BRIEF.md
# Headset Event Status and Interrupt Controller

This block gathers the conditions an audio front end reports about its headset jack, and the other event sources around it, into one 8-bit status word that software reads. Some bits show live levels from the detector, others are sticky event bits. A second register holds the interrupt arming bits and a 4-bit headset debounce code, which a neighbouring debounce block decodes. One registered, active-high interrupt line tells the host that some armed source is pending.

Each interrupt source has its own clearing rule. A headset IRQ lasts until its arming bit is cleared. A button IRQ lasts until its arming bit is cleared, or until the button has been released and the status word has been written. The two trigger sources clear on any write to the status word. The temperature source clears on a status write or when its arming bit is cleared, but its status bit stays high for as long as the temperature condition lasts. The general-purpose input level can be read but never raises an interrupt. A simple port with address, write strobe, write data and registered read data gives access to both registers.

Top module: `hsd_irq_ctrl`

## Requirements
- R1: Status bits 0 (headset present), 1 (stereo), 2 (microphone) and 3 (button held) show the live detector inputs. A read returns them one cycle after the address is presented.
- R2: A write to address 1 stores write-data bits 6:0 into the control register. Bit 0 arms the headset IRQ, bit 1 arms the button IRQ, bit 2 arms the temperature IRQ, and bits 6:3 are the debounce code that drives `dbnc_code`. Bit 7 reads as 0. Reading an address other than 0 or 1 returns 0.
- R3: A headset change pulse while bit 0 of the control register is set makes a headset IRQ pending. Clearing that bit removes the pending IRQ.
- R4: A button press pulse while bit 1 of the control register is set makes a button IRQ pending. Clearing that bit removes it.
- R5: A status write while the button is still held leaves the button IRQ pending. A status write once the button is released clears it.
- R6: A trigger 1 or trigger 2 pulse sets status bit 4 or 5 and raises the IRQ without any arming bit. Any write to address 0 clears both bits. An event that arrives in the same cycle as the write wins.
- R7: A rising edge of the temperature condition sets a latched temperature event. When control bit 2 is set, it also makes a temperature IRQ pending. A status write clears both. Clearing control bit 2 clears the IRQ.
- R8: Status bit 6 reads 1 whenever the temperature condition is high, including after its event has been cleared.
- R9: Status bit 7 shows the general-purpose input level, and that input never affects `irq`.
- R10: `irq` is registered. It equals the OR of the pending headset, button, trigger and temperature IRQs and changes on the same clock edge that records the cause. Reset clears everything to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_present | input | 1 | Debounced headset present flag |
| hs_stereo | input | 1 | Debounced stereo headset flag |
| hs_mic | input | 1 | Debounced microphone flag |
| btn_level | input | 1 | Debounced button held flag |
| hs_change | input | 1 | One-cycle pulse on any headset status change |
| btn_press | input | 1 | One-cycle pulse on a button press |
| trig1_evt | input | 1 | One-cycle trigger 1 event |
| trig2_evt | input | 1 | One-cycle trigger 2 event |
| temp_cond | input | 1 | Temperature condition level |
| gp_in | input | 1 | General-purpose input level |
| reg_addr | input | AW | Register address: 0 status, 1 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| rd_data | output | DW | Registered read data for the previous cycle's address |
| dbnc_code | output | 4 | Headset debounce code from the control register |
| irq | output | 1 | Active-high interrupt request |

## Verification
Several rules hold on every cycle, and the assertions check them there. A pending flag drops in the cycle after its keep condition falls. The button IRQ survives a status write while the button is held. Trigger bits clear on a status write that carries no new event. Status bit 6 and bit 7 follow the temperature condition and the general-purpose input. `irq` never rises without a pending source. Other behaviour needs ordered stimulus and only the bench scenarios can show it: the press, write, release, write sequence for the button, the event that collides with a clearing write, temperature persisting after its IRQ is cleared, and the enable-register writes that drop a pending headset IRQ.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  // status word bit positions (software decodes these)
  localparam int B_HS   = 0;
  localparam int B_ST   = 1;
  localparam int B_MIC  = 2;
  localparam int B_BTN  = 3;
  localparam int B_T1   = 4;
  localparam int B_T2   = 5;
  localparam int B_TMP  = 6;
  localparam int B_GP   = 7;
  // control register fields
  localparam int EN_HS    = 0;
  localparam int EN_BTN   = 1;
  localparam int EN_TMP   = 2;
  localparam int DBNC_LSB = 3;
  localparam int DBNC_W   = 4;
  localparam int CFG_W    = DBNC_LSB + DBNC_W;
  // sticky flag indices
  localparam int F_HS   = 0;
  localparam int F_BTN  = 1;
  localparam int F_T1   = 2;
  localparam int F_T2   = 3;
  localparam int F_TIRQ = 4;
  localparam int F_TLAT = 5;
  localparam int N_FLAGS = 6;
  localparam int N_IRQ   = 5;  // flags 0..4 feed the interrupt line
endpackage

// File: rtl/hsd_sticky_flag.sv
module hsd_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic keep_i,
  output logic q_o,
  output logic nxt_o
);
  // set wins over clear; keep low forces the flag off
  always_comb nxt_o = keep_i & (set_i | (q_o & ~clr_i));

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

  // R3
  keep_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !keep_i |=> !q_o);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && keep_i) |=> q_o);
endmodule

// File: rtl/hsd_cfg_reg.sv
module hsd_cfg_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  always_comb nxt_o = wr_i ? wdata_i : q_o;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/hsd_rd_view.sv
module hsd_rd_view #(
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int STATUS_ADDR = 0,
  parameter int CFG_ADDR    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] cfg_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] sel;

  always_comb begin
    if (addr_i == AW'(STATUS_ADDR))   sel = status_i;
    else if (addr_i == AW'(CFG_ADDR)) sel = cfg_i;
    else                              sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_o <= '0;
    else     rd_o <= sel;
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i != AW'(STATUS_ADDR) && addr_i != AW'(CFG_ADDR)) |=> (rd_o == '0));
endmodule

// File: rtl/hsd_irq_ctrl.sv
module hsd_irq_ctrl
  import hsd_pkg::*;
#(
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int STATUS_ADDR = 0,
  parameter int CFG_ADDR    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hs_present,
  input  logic          hs_stereo,
  input  logic          hs_mic,
  input  logic          btn_level,
  input  logic          hs_change,
  input  logic          btn_press,
  input  logic          trig1_evt,
  input  logic          trig2_evt,
  input  logic          temp_cond,
  input  logic          gp_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] rd_data,
  output logic [DW_DBNC-1:0] dbnc_code,
  output logic          irq
);
  localparam int DW_DBNC = DBNC_W;

  logic st_wr, cfg_wr;
  logic temp_prev, temp_rise;
  logic [CFG_W-1:0] cfg_q, cfg_nxt;
  logic [N_FLAGS-1:0] set_v, clr_v, keep_v, flag_q, flag_nxt;
  logic [DW-1:0] status_vec, cfg_view;
  logic unused_wbits;

  assign st_wr  = reg_wr && (reg_addr == AW'(STATUS_ADDR));
  assign cfg_wr = reg_wr && (reg_addr == AW'(CFG_ADDR));
  assign unused_wbits = ^reg_wdata[DW-1:CFG_W];

  hsd_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(cfg_wr), .wdata_i(reg_wdata[CFG_W-1:0]),
    .q_o(cfg_q), .nxt_o(cfg_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) temp_prev <= 1'b0;
    else     temp_prev <= temp_cond;
  end
  assign temp_rise = temp_cond & ~temp_prev;

  // per-source set / clear / keep rules
  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    keep_v = '1;
    set_v[F_HS]   = hs_change;
    keep_v[F_HS]  = cfg_nxt[EN_HS];
    set_v[F_BTN]  = btn_press;
    clr_v[F_BTN]  = st_wr & ~btn_level;
    keep_v[F_BTN] = cfg_nxt[EN_BTN];
    set_v[F_T1]   = trig1_evt;
    clr_v[F_T1]   = st_wr;
    set_v[F_T2]   = trig2_evt;
    clr_v[F_T2]   = st_wr;
    set_v[F_TIRQ] = temp_rise;
    clr_v[F_TIRQ] = st_wr;
    keep_v[F_TIRQ]= cfg_nxt[EN_TMP];
    set_v[F_TLAT] = temp_rise;
    clr_v[F_TLAT] = st_wr;
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    hsd_sticky_flag u_flag (
      .clk(clk), .rst(rst), .set_i(set_v[i]), .clr_i(clr_v[i]),
      .keep_i(keep_v[i]), .q_o(flag_q[i]), .nxt_o(flag_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |flag_nxt[N_IRQ-1:0];
  end

  always_comb begin
    status_vec         = '0;
    status_vec[B_HS]   = hs_present;
    status_vec[B_ST]   = hs_stereo;
    status_vec[B_MIC]  = hs_mic;
    status_vec[B_BTN]  = btn_level;
    status_vec[B_T1]   = flag_q[F_T1];
    status_vec[B_T2]   = flag_q[F_T2];
    status_vec[B_TMP]  = flag_q[F_TLAT] | temp_cond;
    status_vec[B_GP]   = gp_in;
    cfg_view           = '0;
    cfg_view[CFG_W-1:0]= cfg_q;
  end

  hsd_rd_view #(.AW(AW), .DW(DW), .STATUS_ADDR(STATUS_ADDR), .CFG_ADDR(CFG_ADDR)) u_view (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .status_i(status_vec),
    .cfg_i(cfg_view), .rd_o(rd_data)
  );

  assign dbnc_code = cfg_q[DBNC_LSB +: DBNC_W];

  // R5
  btn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q[F_BTN] && btn_level && !(cfg_wr && !reg_wdata[EN_BTN])) |=> flag_q[F_BTN]);
  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wr && !trig1_evt && !trig2_evt) |=> (!flag_q[F_T1] && !flag_q[F_T2]));
  // R8
  temp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == AW'(STATUS_ADDR) && temp_cond) |=> rd_data[B_TMP]);
  // R9
  gp_view_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == AW'(STATUS_ADDR)) |=> (rd_data[B_GP] == $past(gp_in)));
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|flag_q[N_IRQ-1:0]));
  // R2
  cfg_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == AW'(CFG_ADDR)) |=> !rd_data[DW-1]);
endmodule

// File: tb/hsd_irq_ctrl_bench.sv
module hsd_irq_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst;
  logic hs_present, hs_stereo, hs_mic, btn_level, hs_change, btn_press;
  logic trig1_evt, trig2_evt, temp_cond, gp_in;
  logic [1:0] reg_addr;
  logic reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] rd_data;
  logic [3:0] dbnc_code;
  logic irq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  hsd_irq_ctrl u_hsd_irq_ctrl (
    .clk(clk), .rst(rst), .hs_present(hs_present), .hs_stereo(hs_stereo),
    .hs_mic(hs_mic), .btn_level(btn_level), .hs_change(hs_change),
    .btn_press(btn_press), .trig1_evt(trig1_evt), .trig2_evt(trig2_evt),
    .temp_cond(temp_cond), .gp_in(gp_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .dbnc_code(dbnc_code), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_en, m_hs, m_btn, m_t1, m_t2, m_tlat, m_tirq, m_tprev;
  int e_rd, e_irq, e_cls;
  bit m_valid = 0;

  always @(posedge clk) begin
    int stw, cfw, en_n, rise;
    if (rst) begin
      m_en = 0; m_hs = 0; m_btn = 0; m_t1 = 0; m_t2 = 0;
      m_tlat = 0; m_tirq = 0; m_tprev = 0;
      e_rd = 0; e_irq = 0; e_cls = 3;
    end else begin
      case (reg_addr)
        2'd0: begin
          e_rd = int'(hs_present) + 2*int'(hs_stereo) + 4*int'(hs_mic) + 8*int'(btn_level)
               + 16*m_t1 + 32*m_t2 + 64*((m_tlat != 0 || temp_cond) ? 1 : 0) + 128*int'(gp_in);
          e_cls = 0;
        end
        2'd1: begin e_rd = m_en; e_cls = 1; end
        default: begin e_rd = 0; e_cls = 2; end
      endcase
      stw  = (reg_wr && reg_addr == 2'd0) ? 1 : 0;
      cfw  = (reg_wr && reg_addr == 2'd1) ? 1 : 0;
      en_n = cfw ? int'(reg_wdata) % 128 : m_en;
      rise = (temp_cond && m_tprev == 0) ? 1 : 0;
      m_hs  = ((en_n % 2) == 1 && (hs_change || m_hs != 0)) ? 1 : 0;
      if ((en_n / 2) % 2 == 0) m_btn = 0;
      else if (btn_press) m_btn = 1;
      else if (stw != 0 && !btn_level) m_btn = 0;
      m_t1 = trig1_evt ? 1 : (stw != 0 ? 0 : m_t1);
      m_t2 = trig2_evt ? 1 : (stw != 0 ? 0 : m_t2);
      m_tlat = rise != 0 ? 1 : (stw != 0 ? 0 : m_tlat);
      if ((en_n / 4) % 2 == 0) m_tirq = 0;
      else if (rise != 0) m_tirq = 1;
      else if (stw != 0) m_tirq = 0;
      m_tprev = temp_cond ? 1 : 0;
      m_en = en_n;
      e_irq = (m_hs | m_btn | m_t1 | m_t2 | m_tirq) != 0 ? 1 : 0;
    end
    m_valid = 1;
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R10 irq vs model", int'(irq), e_irq);
      chk("R2 dbnc_code vs model", int'(dbnc_code), (m_en / 8) % 16);
      case (e_cls)
        0: begin
          chk("R1 live bits", int'(rd_data[3:0]), e_rd % 16);
          chk("R6 trigger bits", int'(rd_data[5:4]), (e_rd / 16) % 4);
          chk("R8 temperature bit", int'(rd_data[6]), (e_rd / 64) % 2);
          chk("R9 gp bit", int'(rd_data[7]), e_rd / 128);
        end
        1: chk("R2 control read", int'(rd_data), e_rd);
        2: chk("R2 unmapped read", int'(rd_data), 0);
        default: chk("R10 reset read", int'(rd_data), 0);
      endcase
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    @(negedge clk);
    v = rd_data;
    reg_addr = 2'd0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1;
    {hs_present, hs_stereo, hs_mic, btn_level, hs_change, btn_press} = '0;
    {trig1_evt, trig2_evt, temp_cond, gp_in} = '0;
    reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'd0;
    repeat (3) @(negedge clk);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset rd_data", int'(rd_data), 0);
    rst = 1'b0;
    @(negedge clk);

    // control register: arm all, debounce code 5
    wr_reg(2'd1, 8'hAF);
    rd_reg(2'd1, v);
    chk("R2 control readback masks bit 7", int'(v), 8'h2F);
    chk("R2 debounce code", int'(dbnc_code), 5);
    rd_reg(2'd2, v);
    chk("R2 unmapped address", int'(v), 0);

    // headset insertion
    hs_present = 1; hs_stereo = 1; hs_change = 1;
    @(negedge clk); hs_change = 0;
    chk("R3 headset IRQ raised", int'(irq), 1);
    rd_reg(2'd0, v);
    chk("R1 live headset bits", int'(v[3:0]), 3);
    wr_reg(2'd0, 8'h00);
    chk("R3 status write keeps headset IRQ", int'(irq), 1);
    wr_reg(2'd1, 8'h2E);
    chk("R3 disarm clears headset IRQ", int'(irq), 0);

    // button sequence
    btn_level = 1; btn_press = 1;
    @(negedge clk); btn_press = 0;
    chk("R4 button IRQ raised", int'(irq), 1);
    wr_reg(2'd0, 8'h00);
    chk("R5 held button survives status write", int'(irq), 1);
    btn_level = 0;
    @(negedge clk);
    chk("R5 release alone keeps IRQ", int'(irq), 1);
    wr_reg(2'd0, 8'h00);
    chk("R5 release then write clears", int'(irq), 0);
    btn_level = 1; btn_press = 1;
    @(negedge clk); btn_press = 0;
    wr_reg(2'd1, 8'h2C);
    chk("R4 disarm clears button IRQ", int'(irq), 0);
    btn_level = 0;

    // triggers
    trig1_evt = 1;
    @(negedge clk); trig1_evt = 0;
    chk("R6 trigger 1 raises IRQ unarmed", int'(irq), 1);
    rd_reg(2'd0, v);
    chk("R6 trigger 1 status bit", int'(v[4]), 1);
    wr_reg(2'd0, 8'h00);
    chk("R6 status write clears trigger", int'(irq), 0);
    trig2_evt = 1;
    wr_reg(2'd0, 8'h00);
    trig2_evt = 0;
    chk("R6 event beats same-cycle write", int'(irq), 1);
    wr_reg(2'd0, 8'h00);
    chk("R6 second write clears", int'(irq), 0);

    // temperature
    temp_cond = 1;
    @(negedge clk);
    chk("R7 temperature IRQ raised", int'(irq), 1);
    wr_reg(2'd0, 8'h00);
    chk("R7 status write clears temperature IRQ", int'(irq), 0);
    rd_reg(2'd0, v);
    chk("R8 bit 6 persists with condition", int'(v[6]), 1);
    temp_cond = 0;
    @(negedge clk);
    rd_reg(2'd0, v);
    chk("R8 bit 6 drops after condition and clear", int'(v[6]), 0);
    temp_cond = 1;
    @(negedge clk);
    chk("R7 second rise raises IRQ", int'(irq), 1);
    wr_reg(2'd1, 8'h28);
    chk("R7 disarm clears temperature IRQ", int'(irq), 0);
    temp_cond = 0;
    wr_reg(2'd0, 8'h00);

    // general-purpose input
    gp_in = 1;
    @(negedge clk);
    chk("R9 gp input no IRQ", int'(irq), 0);
    rd_reg(2'd0, v);
    chk("R9 gp input status bit", int'(v[7]), 1);
    gp_in = 0;

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        hs_present = 1'($urandom); hs_stereo = 1'($urandom); hs_mic = 1'($urandom);
        hs_change = 1;
      end else hs_change = 0;
      if ($urandom_range(0, 7) == 0) btn_level = ~btn_level;
      btn_press = ($urandom_range(0, 15) == 0);
      trig1_evt = ($urandom_range(0, 31) == 0);
      trig2_evt = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 31) == 0) temp_cond = ~temp_cond;
      gp_in = 1'($urandom);
      reg_addr = 2'($urandom);
      reg_wr = ($urandom_range(0, 7) == 0);
      reg_wdata = 8'($urandom);
      @(negedge clk);
    end
    reg_wr = 0; hs_change = 0; btn_press = 0; trig1_evt = 0; trig2_evt = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule